// File: doc/BRIEF.md
# Peripheral Bus Region Decoder with Wait-State Timing

This block sits between a CPU's access strobes and the on-chip peripheral bus. For each access it decodes a 24-bit address into one of five on-chip regions: an extension RAM, two message controllers, a PWM unit and a group of miscellaneous peripherals. Anything that no enabled region claims goes to the external memory interface. For every access exactly one select line is raised. The ready output is withheld for as many cycles as the chosen region needs.

Visibility has two levels. A global peripheral-bus enable must be set, and so must each region's own bit in a selection register. The selection value is captured at the moment the global enable is first seen high. From then on the visible set is frozen until reset. A bit that was still clear at that moment leaves its region permanently unclaimed, so accesses to it fall through to the external interface. Reads and writes are decoded the same way. Byte and word accesses are not distinguished.

Top module: `pbus_decode`

## Requirements
- R1: With the enable latched and selection bit 2 captured set, an access in 0x008000..0x00BFFF raises only `xram_sel_o`, and `rdy_o` is high in the first cycle of the access.
- R2: An access to the address range of a region that is not visible raises `ext_sel_o` instead. This includes the extension RAM range while the global enable is off.
- R3: Message controller 1 answers 0x00EF00..0x00EFFF when bit 0 was captured. Message controller 2 answers 0x00EE00..0x00EEFF when bit 1 was captured.
- R4: The PWM unit answers 0x00EC00..0x00ECFF when bit 4 was captured.
- R5: An access to either message controller or to the PWM unit holds `rdy_o` low in its first two cycles and raises it in the third.
- R6: The miscellaneous group answers 0x00C000..0x00C3FF when bit 3 was captured, with `rdy_o` high in the first cycle.
- R7: The selection value is sampled in the first cycle that `gen_i` is high. After that, changes to `psel_i` and clearing `gen_i` have no effect until reset. A bit that was clear at the sampling cycle stays invisible.
- R8: During an access (`rd_i` or `wr_i` high) exactly one select is high. With no access, all selects and `rdy_o` are low. Addresses outside every visible region raise only `ext_sel_o`, with `rdy_o` high in the first cycle.
- R9: After reset the enable and the captured selection are clear, so every access goes to `ext_sel_o`.
- R10: If the address changes while a wait is still in progress, the change counts as a new access and the wait count starts again from zero for the new region.
- R11: Reads and writes are decoded and timed identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 24 | Access address |
| rd_i | input | 1 | Read strobe, held until ready |
| wr_i | input | 1 | Write strobe, held until ready |
| gen_i | input | 1 | Global peripheral-bus enable |
| psel_i | input | 5 | Per-region selection register value |
| xram_sel_o | output | 1 | Extension RAM select |
| msg1_sel_o | output | 1 | Message controller 1 select |
| msg2_sel_o | output | 1 | Message controller 2 select |
| pwm_sel_o | output | 1 | PWM unit select |
| misc_sel_o | output | 1 | Miscellaneous group select |
| ext_sel_o | output | 1 | External memory interface select |
| rdy_o | output | 1 | Access complete |

## Verification
Two functions can meet in one cycle: the wait counter advancing for a slow region, and the decoder switching to a new region. The bench drives a PWM address and then, one cycle later, with `rdy_o` still low, moves to a message controller address. It then requires the new select and a fresh run of two low-ready cycles, measured from the change. A second overlap joins a selection-register write with the already-latched enable. Here the judgement is that the region's range keeps going to the external select.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   localparam int PKG_AW = 24;
   localparam int NREG   = 5;

   localparam int RG_XRAM = 0;
   localparam int RG_MSG1 = 1;
   localparam int RG_MSG2 = 2;
   localparam int RG_PWM  = 3;
   localparam int RG_MISC = 4;

   localparam logic [PKG_AW-1:0] RG_LO [NREG] = '{24'h008000, 24'h00EF00, 24'h00EE00, 24'h00EC00, 24'h00C000};
   localparam logic [PKG_AW-1:0] RG_HI [NREG] = '{24'h00BFFF, 24'h00EFFF, 24'h00EEFF, 24'h00ECFF, 24'h00C3FF};
   localparam int RG_BIT [NREG] = '{2, 0, 1, 4, 3};
   localparam int RG_WS  [NREG] = '{0, 2, 2, 2, 0};

   function automatic int max_ws();
      int m = 0;
      for (int i = 0; i < NREG; i++) if (RG_WS[i] > m) m = RG_WS[i];
      return m;
   endfunction

   function automatic int max_bit();
      int m = 0;
      for (int i = 0; i < NREG; i++) if (RG_BIT[i] > m) m = RG_BIT[i];
      return m;
   endfunction
endpackage

// File: rtl/pbus_cfg_latch.sv
module pbus_cfg_latch #(
   parameter int SEL_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             gen_i,
   input  logic [SEL_W-1:0] psel_i,
   output logic             en_o,
   output logic [SEL_W-1:0] vis_o
);
   logic             en_q;
   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else if (!en_q && gen_i) begin
         en_q  <= 1'b1;
         sel_q <= psel_i;
      end
   end

   assign en_o  = en_q;
   assign vis_o = en_q ? sel_q : '0;
endmodule

// File: rtl/pbus_match.sv
module pbus_match #(
   parameter int            AW = 24,
   parameter logic [AW-1:0] LO = '0,
   parameter logic [AW-1:0] HI = '1
) (
   input  logic [AW-1:0] addr_i,
   output logic          hit_o
);
   if (LO > HI) begin : g_bad_range
      $error("pbus_match: empty range");
   end

   assign hit_o = (addr_i >= LO) && (addr_i <= HI);
endmodule

// File: rtl/pbus_wait_ctr.sv
module pbus_wait_ctr #(
   parameter int AW    = 24,
   parameter int CNT_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             acc_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [CNT_W-1:0] ws_i,
   output logic             rdy_o
);
   logic             act_q;
   logic [AW-1:0]    addr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             new_acc;
   logic [CNT_W-1:0] elapsed;

   assign new_acc = acc_i && (!act_q || (addr_i != addr_q));
   assign elapsed = new_acc ? '0 : cnt_q;
   assign rdy_o   = acc_i && (elapsed == ws_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q  <= 1'b0;
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (!acc_i || rdy_o) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         act_q  <= 1'b1;
         addr_q <= addr_i;
         cnt_q  <= elapsed + CNT_W'(1);
      end
   end
endmodule

// File: rtl/pbus_decode.sv
module pbus_decode
   import pbus_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int SEL_W  = 5,
   parameter int CNT_W  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic              gen_i,
   input  logic [SEL_W-1:0]  psel_i,
   output logic              xram_sel_o,
   output logic              msg1_sel_o,
   output logic              msg2_sel_o,
   output logic              pwm_sel_o,
   output logic              misc_sel_o,
   output logic              ext_sel_o,
   output logic              rdy_o
);
   localparam int MAX_WS  = max_ws();
   localparam int MAX_BIT = max_bit();

   if (ADDR_W != PKG_AW) begin : g_bad_aw
      $error("pbus_decode: ADDR_W must match the region table");
   end
   if (MAX_WS >= (1 << CNT_W)) begin : g_bad_cnt
      $error("pbus_decode: CNT_W too narrow for wait states");
   end
   if (MAX_BIT >= SEL_W) begin : g_bad_sel
      $error("pbus_decode: SEL_W too narrow for selection bits");
   end

   logic              acc;
   logic              cfg_en;
   logic [SEL_W-1:0]  vis;
   logic [NREG-1:0]   hit_en;
   logic [NREG-1:0]   sel_vec;
   logic [CNT_W-1:0]  ws_need;

   assign acc = rd_i | wr_i;

   pbus_cfg_latch #(.SEL_W(SEL_W)) u_cfg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .gen_i  (gen_i),
      .psel_i (psel_i),
      .en_o   (cfg_en),
      .vis_o  (vis)
   );

   for (genvar r = 0; r < NREG; r++) begin : g_rg
      logic hit;
      pbus_match #(
         .AW (ADDR_W),
         .LO (ADDR_W'(RG_LO[r])),
         .HI (ADDR_W'(RG_HI[r]))
      ) u_match (
         .addr_i (addr_i),
         .hit_o  (hit)
      );
      assign hit_en[r]  = hit & vis[RG_BIT[r]];
      assign sel_vec[r] = acc & hit_en[r];
   end

   always_comb begin
      ws_need = '0;
      for (int r = 0; r < NREG; r++) begin
         if (hit_en[r]) ws_need = ws_need | CNT_W'(RG_WS[r]);
      end
   end

   pbus_wait_ctr #(.AW(ADDR_W), .CNT_W(CNT_W)) u_wait (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .acc_i  (acc),
      .addr_i (addr_i),
      .ws_i   (ws_need),
      .rdy_o  (rdy_o)
   );

   assign xram_sel_o = sel_vec[RG_XRAM];
   assign msg1_sel_o = sel_vec[RG_MSG1];
   assign msg2_sel_o = sel_vec[RG_MSG2];
   assign pwm_sel_o  = sel_vec[RG_PWM];
   assign misc_sel_o = sel_vec[RG_MISC];
   assign ext_sel_o  = acc & ~(|hit_en);
endmodule

// File: rtl/pbus_decode_chk.sv
module pbus_decode_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic rd_i,
   input logic wr_i,
   input logic cfg_en,
   input logic xram_sel_o,
   input logic msg1_sel_o,
   input logic msg2_sel_o,
   input logic pwm_sel_o,
   input logic misc_sel_o,
   input logic ext_sel_o,
   input logic rdy_o
);
   logic [5:0] sels;
   logic       slow;
   logic       fast;
   assign sels = {ext_sel_o, misc_sel_o, pwm_sel_o, msg2_sel_o, msg1_sel_o, xram_sel_o};
   assign slow = msg1_sel_o | msg2_sel_o | pwm_sel_o;
   assign fast = xram_sel_o | misc_sel_o | ext_sel_o;

   // R8
   sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i || wr_i) |-> $countones(sels) == 1);

   // R8
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_i || wr_i) |-> (sels == 6'b0 && !rdy_o));

   // R9
   reset_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_en && (rd_i || wr_i)) |-> ext_sel_o);

   // R1 R6
   fast_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fast |-> rdy_o);

   // R5
   slow_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slow && rdy_o) |-> ($past(slow && !rdy_o, 1) && $past(slow && !rdy_o, 2)));

   // R7
   cfg_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_en |=> cfg_en);
endmodule

bind pbus_decode pbus_decode_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .rd_i       (rd_i),
   .wr_i       (wr_i),
   .cfg_en     (cfg_en),
   .xram_sel_o (xram_sel_o),
   .msg1_sel_o (msg1_sel_o),
   .msg2_sel_o (msg2_sel_o),
   .pwm_sel_o  (pwm_sel_o),
   .misc_sel_o (misc_sel_o),
   .ext_sel_o  (ext_sel_o),
   .rdy_o      (rdy_o)
);

// File: tb/pbus_decode_bench.sv
module pbus_decode_bench;
   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic [23:0] addr_i;
   logic        rd_i, wr_i, gen_i;
   logic [4:0]  psel_i;
   logic        xram_sel_o, msg1_sel_o, msg2_sel_o, pwm_sel_o, misc_sel_o, ext_sel_o, rdy_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // select code: {ext, misc, pwm, msg2, msg1, xram}
   localparam logic [5:0] S_XRAM = 6'b000001;
   localparam logic [5:0] S_MSG1 = 6'b000010;
   localparam logic [5:0] S_MSG2 = 6'b000100;
   localparam logic [5:0] S_PWM  = 6'b001000;
   localparam logic [5:0] S_MISC = 6'b010000;
   localparam logic [5:0] S_EXT  = 6'b100000;

   // vector: {write, waits[1:0], select[5:0], address[23:0]}, all regions enabled
   localparam int NV = 16;
   localparam logic [32:0] VEC [NV] = '{
      {1'b0, 2'd0, S_XRAM, 24'h008000},
      {1'b1, 2'd0, S_XRAM, 24'h00BFFF},
      {1'b0, 2'd0, S_EXT,  24'h007FFF},
      {1'b0, 2'd0, S_MISC, 24'h00C000},
      {1'b1, 2'd0, S_MISC, 24'h00C3FF},
      {1'b0, 2'd0, S_EXT,  24'h00C400},
      {1'b0, 2'd2, S_PWM,  24'h00EC00},
      {1'b1, 2'd2, S_PWM,  24'h00ECFF},
      {1'b0, 2'd0, S_EXT,  24'h00ED00},
      {1'b0, 2'd2, S_MSG2, 24'h00EE00},
      {1'b1, 2'd2, S_MSG2, 24'h00EEFF},
      {1'b0, 2'd2, S_MSG1, 24'h00EF00},
      {1'b1, 2'd2, S_MSG1, 24'h00EFFF},
      {1'b0, 2'd0, S_EXT,  24'h00F000},
      {1'b1, 2'd0, S_EXT,  24'h018000},
      {1'b0, 2'd0, S_EXT,  24'hFFFFFF}
   };

   pbus_decode u_pbus_decode (
      .clk_i (clk_i), .rst_ni (rst_ni), .addr_i (addr_i), .rd_i (rd_i), .wr_i (wr_i),
      .gen_i (gen_i), .psel_i (psel_i),
      .xram_sel_o (xram_sel_o), .msg1_sel_o (msg1_sel_o), .msg2_sel_o (msg2_sel_o),
      .pwm_sel_o (pwm_sel_o), .misc_sel_o (misc_sel_o), .ext_sel_o (ext_sel_o), .rdy_o (rdy_o)
   );

   always #10 clk_i = ~clk_i;

   function automatic logic [5:0] sels();
      return {ext_sel_o, misc_sel_o, pwm_sel_o, msg2_sel_o, msg1_sel_o, xram_sel_o};
   endfunction

   function automatic string req_of(logic [5:0] s);
      case (s)
         S_XRAM: return "R1";
         S_MSG1, S_MSG2: return "R3";
         S_PWM:  return "R4";
         S_MISC: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_ni = 1'b0; addr_i = '0; rd_i = 0; wr_i = 0; gen_i = 0; psel_i = '0;
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
   endtask

   task automatic enable(logic [4:0] s);
      @(negedge clk_i);
      psel_i = s; gen_i = 1'b1;
      @(negedge clk_i);
   endtask

   // drive one access, measure low-ready cycles, check select and waits
   task automatic access(logic [23:0] a, bit w, logic [5:0] es, int ews, string req);
      int waits = 0;
      logic [5:0] got;
      @(negedge clk_i);
      addr_i = a; rd_i = !w; wr_i = w;
      #1;
      while (!rdy_o && waits < 8) begin
         @(negedge clk_i); #1;
         waits++;
      end
      got = sels();
      chk(got == es, req, int'(got), int'(es));
      chk(waits == ews, (ews == 2) ? "R5" : req, waits, ews);
      @(negedge clk_i);
      rd_i = 0; wr_i = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R9: reset state, idle outputs quiet, everything external
      do_reset();
      @(negedge clk_i); #1;
      chk(sels() == 6'b0 && !rdy_o, "R9", int'({sels(), rdy_o}), 0);
      access(24'h008000, 0, S_EXT, 0, "R9");
      access(24'h00EF00, 0, S_EXT, 0, "R9");
      // R2: selection set but global enable off
      psel_i = 5'h1F;
      access(24'h008000, 0, S_EXT, 0, "R2");

      // main table, all regions visible (R11 via write vectors)
      enable(5'h1F);
      for (int i = 0; i < NV; i++) begin
         logic [32:0] v = VEC[i];
         access(v[23:0], v[32], v[29:24], int'(v[31:30]), v[32] ? "R11" : req_of(v[29:24]));
      end

      // R10: address change mid-wait restarts the count
      begin
         int waits = 0;
         @(negedge clk_i);
         addr_i = 24'h00EC00; rd_i = 1;
         @(negedge clk_i);
         addr_i = 24'h00EE00;
         #1;
         while (!rdy_o && waits < 8) begin
            @(negedge clk_i); #1;
            waits++;
         end
         chk(sels() == S_MSG2, "R10", int'(sels()), int'(S_MSG2));
         chk(waits == 2, "R10", waits, 2);
         @(negedge clk_i);
         rd_i = 0;
      end

      // R7 / R2: partial selection latched at enable
      do_reset();
      enable(5'b00101);
      access(24'h00EF00, 0, S_MSG1, 2, "R3");
      access(24'h008000, 0, S_XRAM, 0, "R1");
      access(24'h00EE00, 0, S_EXT, 0, "R7");
      access(24'h00C000, 0, S_EXT, 0, "R2");
      psel_i = 5'h1F;
      access(24'h00EC00, 0, S_EXT, 0, "R7");
      gen_i = 1'b0;
      access(24'h008000, 1, S_XRAM, 0, "R7");

      // R7: selection written after enable stays invisible
      do_reset();
      enable(5'b00000);
      psel_i = 5'h1F;
      access(24'h008000, 0, S_EXT, 0, "R7");
      access(24'h00C3FF, 0, S_EXT, 0, "R7");

      // R9: reset clears a previous enable
      do_reset();
      access(24'h00EC00, 0, S_EXT, 0, "R9");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule